// File: doc/BRIEF.md
# Security Attribution Region Checker

This block decides, for every bus access, which security label the target address carries: Secure, Non-Secure, or Non-Secure-Callable. Software programs a small bank of address windows, each of which can grant Non-Secure or Non-Secure-Callable status. Any address that no enabled window claims stays Secure. When the unit is switched off, every address is Secure. Non-Secure space therefore has to be opened on purpose, and the callable label marks the only places where gateway entry stubs may sit.

Each access arrives with its address and the state of the requester, Secure or Non-Secure. The label comes out combinationally in the same cycle. A deny flag blocks the data return when a Non-Secure requester reaches a Secure-labelled address. One cycle later a single-cycle fault pulse follows, and a sticky status word records the violation together with an address-valid flag. The address of that first fault is held until software clears the valid flag.

Register map (word index on `reg_idx`):
- 0 is control: bit 0 is the unit enable.
- 1 is status: bit 3 is the violation bit and bit 6 is address-valid. Writing 1 to a bit clears it.
- 2 is the fault address (read-only).
- 4+2i is the base of window i, bits [31:5].
- 5+2i is the limit of window i: bits [31:5] hold the limit, bit 1 selects callable, and bit 0 enables the window.

Top module: `sec_attr_unit`

## Requirements
- R1: After reset the control, status and fault-address words read 0, every window is disabled, and every address is labelled Secure.
- R2: Control bit 0 enables the unit. Writing all ones to control reads back 0x00000001, because every other bit reads 0.
- R3: While the unit is disabled, or when no enabled window matches, `chk_attr` is Secure (encoding 2'b00).
- R4: An enabled window matches when base <= addr[31:5] <= limit, so the limit's whole 32-byte block is included. A matching window labels the address Non-Secure (2'b01) when limit bit 1 is 0, and Non-Secure-Callable (2'b10) when limit bit 1 is 1.
- R5: Where enabled windows overlap, the lowest-numbered window decides the label.
- R6: A valid Non-Secure access to a Secure-labelled address raises `chk_deny` in the same cycle and `fault_pulse` for exactly the following cycle. Accesses to Non-Secure or callable addresses are never denied.
- R7: A fault sets status bits 3 and 6, giving the value 0x48. The bits stay set until 1 is written to them, and each bit clears on its own. A fault in the same cycle as a clear leaves the bit set.
- R8: A fault records its address only while status bit 6 is clear, or when bit 6 is being cleared in the same cycle. Later faults leave the stored address unchanged.
- R9: A Secure-state requester is never denied or faulted, and an access with `chk_valid` low never faults.
- R10: Window base words read back with bits [4:0] zero. Limit words read back with bits [4:2] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| chk_valid | input | 1 | Access present |
| chk_ns | input | 1 | Requester is in Non-Secure state |
| chk_addr | input | 32 | Access address |
| chk_attr | output | 2 | Label: 00 Secure, 01 Non-Secure, 10 Callable |
| chk_deny | output | 1 | Access blocked (same cycle) |
| fault_pulse | output | 1 | One-cycle security fault indication |

## Verification
The embedded properties check the following on every cycle:
- a Secure requester never sees a fault pulse;
- a disabled unit labels everything Secure;
- the label is never the unused code;
- a fault pulse is always matched by both status bits;
- the stored fault address does not move while its valid flag stands.

Some behaviour only the bench scenarios can show. These include which window wins an overlap and the exact inclusive edges of each window. They also include the readback masking, the independent write-1-to-clear of each status bit, and the case of a clear that coincides with a new fault. The bench reaches these through sweeps of the address space under several window layouts.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [1:0] {
    ATTR_S   = 2'b00,
    ATTR_NS  = 2'b01,
    ATTR_NSC = 2'b10
  } sau_attr_e;

  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ST_VIOL_BIT  = 3;
  localparam int unsigned ST_AVAL_BIT  = 6;
  localparam int unsigned IDX_CTRL     = 0;
  localparam int unsigned IDX_STATUS   = 1;
  localparam int unsigned IDX_FADDR    = 2;
  localparam int unsigned IDX_WIN0     = 4;
endpackage

// File: rtl/sau_region.sv
module sau_region #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned GRAN   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_base,
  input  logic                      wr_limit,
  input  logic [sau_pkg::DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0]         addr,
  output logic [sau_pkg::DATA_W-1:0] base_word,
  output logic [sau_pkg::DATA_W-1:0] limit_word,
  output logic                      hit,
  output logic                      nsc
);
  localparam int unsigned BLK_W = ADDR_W - GRAN;

  logic [BLK_W-1:0] base_q, base_d;
  logic [BLK_W-1:0] lim_q, lim_d;
  logic             en_q, en_d;
  logic             nsc_q, nsc_d;

  always_comb begin
    base_d = base_q;
    lim_d  = lim_q;
    en_d   = en_q;
    nsc_d  = nsc_q;
    if (wr_base) begin
      base_d = wdata[ADDR_W-1:GRAN];
    end
    if (wr_limit) begin
      lim_d = wdata[ADDR_W-1:GRAN];
      en_d  = wdata[0];
      nsc_d = wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      en_q   <= 1'b0;
      nsc_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      lim_q  <= lim_d;
      en_q   <= en_d;
      nsc_q  <= nsc_d;
    end
  end

  always_comb begin
    base_word                  = '0;
    base_word[ADDR_W-1:GRAN]   = base_q;
    limit_word                 = '0;
    limit_word[ADDR_W-1:GRAN]  = lim_q;
    limit_word[1]              = nsc_q;
    limit_word[0]              = en_q;
  end

  assign hit = en_q && (addr[ADDR_W-1:GRAN] >= base_q) && (addr[ADDR_W-1:GRAN] <= lim_q);
  assign nsc = nsc_q;
endmodule

// File: rtl/sau_prio.sv
module sau_prio #(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unit_en,
  input  logic [NUM_WIN-1:0] hit,
  input  logic [NUM_WIN-1:0] nsc,
  output sau_pkg::sau_attr_e attr
);
  import sau_pkg::*;

  always_comb begin
    attr = ATTR_S;
    if (unit_en) begin
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
        if (hit[i]) begin
          attr = nsc[i] ? ATTR_NSC : ATTR_NS;
        end
      end
    end
  end

  // R4
  legal_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr != 2'b11);
endmodule

// File: rtl/sau_fault.sv
module sau_fault #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       viol,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       clr_viol,
  input  logic                       clr_aval,
  output logic [sau_pkg::DATA_W-1:0] status_word,
  output logic [sau_pkg::DATA_W-1:0] faddr_word,
  output logic                       fault_pulse
);
  import sau_pkg::*;

  logic              viol_q, viol_d;
  logic              aval_q, aval_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic              pulse_q, pulse_d;
  logic              fa_en;

  assign fa_en = viol && (!aval_q || clr_aval);

  always_comb begin
    viol_d  = (viol_q && !clr_viol) || viol;
    aval_d  = (aval_q && !clr_aval) || viol;
    fa_d    = fa_en ? addr : fa_q;
    pulse_d = viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      aval_q  <= 1'b0;
      fa_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      viol_q  <= viol_d;
      aval_q  <= aval_d;
      fa_q    <= fa_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[ST_VIOL_BIT] = viol_q;
    status_word[ST_AVAL_BIT] = aval_q;
    faddr_word               = '0;
    faddr_word[ADDR_W-1:0]   = fa_q;
  end
  assign fault_pulse = pulse_q;

  // R7
  pulse_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (viol_q && aval_q));

  // R8
  faddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aval_q && !clr_aval) |=> $stable(fa_q));
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned GRAN    = 5,
  localparam int unsigned REG_AW = $clog2(sau_pkg::IDX_WIN0 + 2 * NUM_WIN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [REG_AW-1:0]          reg_idx,
  input  logic [sau_pkg::DATA_W-1:0] reg_wdata,
  output logic [sau_pkg::DATA_W-1:0] reg_rdata,
  input  logic                       chk_valid,
  input  logic                       chk_ns,
  input  logic [ADDR_W-1:0]          chk_addr,
  output logic [1:0]                 chk_attr,
  output logic                       chk_deny,
  output logic                       fault_pulse
);
  import sau_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  // control register
  logic ctrl_en_q, ctrl_en_d, ctrl_wr;
  assign ctrl_wr = reg_we && (reg_idx == REG_AW'(IDX_CTRL));
  always_comb begin
    ctrl_en_d = ctrl_en_q;
    if (ctrl_wr) begin
      ctrl_en_d = reg_wdata[0];
    end
  end
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_en_q <= 1'b0;
    end else begin
      ctrl_en_q <= ctrl_en_d;
    end
  end

  // windows
  logic [NUM_WIN-1:0] hit, nsc;
  logic [DATA_W-1:0]  base_words  [NUM_WIN];
  logic [DATA_W-1:0]  limit_words [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic wr_b, wr_l;
    assign wr_b = reg_we && (reg_idx == REG_AW'(IDX_WIN0 + 2 * g));
    assign wr_l = reg_we && (reg_idx == REG_AW'(IDX_WIN0 + 2 * g + 1));
    sau_region #(.ADDR_W(ADDR_W), .GRAN(GRAN)) i_region (
      .clk        (clk),
      .rst_n      (rst_s_n),
      .wr_base    (wr_b),
      .wr_limit   (wr_l),
      .wdata      (reg_wdata),
      .addr       (chk_addr),
      .base_word  (base_words[g]),
      .limit_word (limit_words[g]),
      .hit        (hit[g]),
      .nsc        (nsc[g])
    );
  end

  sau_attr_e attr;
  sau_prio #(.NUM_WIN(NUM_WIN)) i_prio (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .unit_en (ctrl_en_q),
    .hit     (hit),
    .nsc     (nsc),
    .attr    (attr)
  );

  assign chk_attr = attr;
  assign chk_deny = chk_valid && chk_ns && (attr == ATTR_S);

  // fault capture
  logic              st_wr;
  logic [DATA_W-1:0] status_word, faddr_word;
  assign st_wr = reg_we && (reg_idx == REG_AW'(IDX_STATUS));

  sau_fault #(.ADDR_W(ADDR_W)) i_fault (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .viol        (chk_deny),
    .addr        (chk_addr),
    .clr_viol    (st_wr && reg_wdata[ST_VIOL_BIT]),
    .clr_aval    (st_wr && reg_wdata[ST_AVAL_BIT]),
    .status_word (status_word),
    .faddr_word  (faddr_word),
    .fault_pulse (fault_pulse)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_idx == REG_AW'(IDX_CTRL)) begin
      reg_rdata[0] = ctrl_en_q;
    end else if (reg_idx == REG_AW'(IDX_STATUS)) begin
      reg_rdata = status_word;
    end else if (reg_idx == REG_AW'(IDX_FADDR)) begin
      reg_rdata = faddr_word;
    end
    for (int i = 0; i < NUM_WIN; i++) begin
      if (reg_idx == REG_AW'(IDX_WIN0 + 2 * i)) begin
        reg_rdata = base_words[i];
      end
      if (reg_idx == REG_AW'(IDX_WIN0 + 2 * i + 1)) begin
        reg_rdata = limit_words[i];
      end
    end
  end

  // R9
  secure_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!chk_valid || !chk_ns) |=> !fault_pulse);

  // R3
  disabled_is_secure_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctrl_en_q |-> (chk_attr == 2'b00));

  // R6
  deny_only_ns_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    chk_deny |-> (chk_ns && chk_valid && chk_attr == 2'b00));
endmodule

// File: tb/test_sec_attr_unit.sv
module test_sec_attr_unit;
  localparam int unsigned NW = 4;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        chk_valid = 1'b0;
  logic        chk_ns = 1'b0;
  logic [31:0] chk_addr = '0;
  logic [1:0]  chk_attr;
  logic        chk_deny;
  logic        fault_pulse;

  int n_cmp = 0;
  int n_bad = 0;

  // model of the programmed configuration
  logic        m_on;
  logic        m_en  [NW];
  logic        m_nsc [NW];
  logic [31:0] m_base[NW];
  logic [31:0] m_lim [NW];

  always #(CLK_P / 2) clk = ~clk;

  sec_attr_unit i_sec_attr_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chk_valid(chk_valid),
    .chk_ns(chk_ns), .chk_addr(chk_addr), .chk_attr(chk_attr),
    .chk_deny(chk_deny), .fault_pulse(fault_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = 4'(idx);
    #1 d = reg_rdata;
  endtask

  task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] l,
                         input logic en, input logic c);
    wr(4 + 2 * i, b);
    wr(5 + 2 * i, {l[31:5], 3'b000, c, en});
    m_base[i] = {b[31:5], 5'd0};
    m_lim[i]  = {l[31:5], 5'h1f};
    m_en[i]   = en;
    m_nsc[i]  = c;
  endtask

  function automatic logic [1:0] exp_attr(input logic [31:0] a);
    if (!m_on) return 2'b00;
    for (int i = 0; i < NW; i++) begin
      if (m_en[i] && a >= m_base[i] && a <= m_lim[i]) return m_nsc[i] ? 2'b10 : 2'b01;
    end
    return 2'b00;
  endfunction

  // one access; label and deny checked in-cycle, pulse one cycle later
  task automatic access(input logic [31:0] a, input logic ns, input string req);
    logic [1:0] ea;
    logic       ed;
    ea = exp_attr(a);
    ed = ns && (ea == 2'b00);
    @(negedge clk);
    chk_valid = 1'b1; chk_ns = ns; chk_addr = a;
    #2;
    check({req, " attr"}, 32'(chk_attr), 32'(ea));
    check("R6 deny", 32'(chk_deny), 32'(ed));
    @(negedge clk);
    chk_valid = 1'b0;
    #1 check("R6/R9 fault_pulse", 32'(fault_pulse), 32'(ed));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_on = 1'b0;
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 1'b0; m_nsc[i] = 1'b0; m_base[i] = '0; m_lim[i] = 32'h1f;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 status", d, 0);
    rd(2, d); check("R1 faddr", d, 0);
    for (int i = 0; i < NW; i++) begin
      rd(5 + 2 * i, d); check("R1 limit", d, 0);
    end
    access(32'h0000_0000, 1'b0, "R1");

    // R2 / R10 readback masking
    wr(0, 32'hFFFF_FFFF); rd(0, d); check("R2 ctrl", d, 32'h1);
    m_on = 1'b1;
    wr(4, 32'h1234_567F); rd(4, d); check("R10 base", d, 32'h1234_5660);
    wr(5, 32'hFFFF_FFFE); rd(5, d); check("R10 limit", d, 32'hFFFF_FFE2);

    // layout A: overlap 0 over 1, small callable window, disabled window 3
    set_win(0, 32'h040, 32'h060, 1'b1, 1'b0);
    set_win(1, 32'h060, 32'h0E0, 1'b1, 1'b1);
    set_win(2, 32'h200, 32'h200, 1'b1, 1'b1);
    set_win(3, 32'h300, 32'h3E0, 1'b0, 1'b0);
    for (int a = 0; a < 32'h400; a += 8) begin
      access(32'(a), 1'b1, "R4/R5");
      access(32'(a), 1'b0, "R9");
    end

    // layout B: window 3 overlaps window 2 with a plain label
    set_win(3, 32'h200, 32'h2E0, 1'b1, 1'b0);
    for (int a = 32'h1F0; a < 32'h310; a += 4) access(32'(a), 1'b1, "R5 overlap");

    // unit disabled: everything Secure
    wr(0, 32'h0); m_on = 1'b0;
    for (int a = 0; a < 32'h400; a += 32) access(32'(a), 1'b1, "R3 disabled");
    wr(0, 32'h1); m_on = 1'b1;

    // status and fault address
    wr(1, 32'h48); rd(1, d); check("R7 clear all", d, 0);
    access(32'h124, 1'b1, "R3 no match");
    rd(1, d); check("R7 status", d, 32'h48);
    rd(2, d); check("R8 faddr first", d, 32'h124);
    access(32'h1A8, 1'b1, "R3 no match");
    rd(2, d); check("R8 faddr held", d, 32'h124);
    wr(1, 32'h08); rd(1, d); check("R7 clear viol only", d, 32'h40);
    rd(2, d); check("R8 faddr kept", d, 32'h124);
    wr(1, 32'h40); rd(1, d); check("R7 clear aval", d, 0);
    access(32'h1B0, 1'b1, "R3 no match");
    rd(2, d); check("R8 faddr recapture", d, 32'h1B0);
    // clear and fault in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 4'd1; reg_wdata = 32'h48;
    chk_valid = 1'b1; chk_ns = 1'b1; chk_addr = 32'h3F0;
    @(negedge clk);
    reg_we = 1'b0; chk_valid = 1'b0;
    #1 check("R6 pulse on clear", 32'(fault_pulse), 1);
    rd(1, d); check("R7 fault beats clear", d, 32'h48);
    rd(2, d); check("R8 capture on clear", d, 32'h3F0);
    // secure requester and idle requester leave status untouched
    wr(1, 32'h48);
    access(32'h100, 1'b0, "R9 secure");
    @(negedge clk);
    chk_valid = 1'b0; chk_ns = 1'b1; chk_addr = 32'h100;
    @(negedge clk);
    #1 check("R9 idle no pulse", 32'(fault_pulse), 0);
    rd(1, d); check("R9 status untouched", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule